// File: doc/BRIEF.md
# Double-Data-Rate Read Burst Sequencer

This block is the read side of a double-data-rate memory device, seen from the device. Decoded commands arrive once per device clock: activate, read or no-operation, each with bank and address inputs. An activate opens a row in one of four banks. A read names a starting column and is checked against the open-row state and the activate-to-read spacing. An accepted read becomes a burst of 2, 4 or 8 words after the programmed latency, and it is framed by a strobe. A small mode store holds the burst length code, the latency in device cycles and the column ordering.

The block runs on one clock at twice the device rate, so every register boundary is a half-cycle slot. Device rising edges are the odd-numbered edges counted from the end of reset: edge 1, 3, 5 and so on. Commands and mode writes are sampled only on those edges. The block asks an external synchronous array for each word one slot ahead of time, using a request strobe with bank, row and column. It then forwards the returned word on the data output in the following slot. The data and the strobe each have their own output-enable.

Top module: `ddrrd_read_seq`

## Requirements
- R1: A READ to a bank that no ACT has opened pulses `cmd_err` high for the one slot after the sampling edge, and produces no strobe, data or array request.
- R2: A READ to an open bank sampled fewer than TRCD device cycles after that bank's ACT is rejected in the same way as in R1. A READ exactly TRCD device cycles after the ACT is accepted.
- R3: A mode write sets the burst length from `mode_blc` (1 gives 2 words, 2 gives 4, 3 gives 8) and the latency from `mode_cl` (2 or 3). Code 0 for the burst length leaves the old value. A latency code outside 2..3 leaves the old value. `mode_bt` selects the ordering: 0 is sequential, 1 is interleaved.
- R4: For a READ sampled on edge T with latency CL, the first word is driven in slot T+2·CL.
- R5: Word k of a burst of length N starting at column C reads column (C with its low log2(N) bits cleared) plus an offset. The offset is (C mod N + k) mod N for sequential ordering and (C mod N) XOR k for interleaved ordering.
- R6: In slots T+2·CL−2 and T+2·CL−1 the strobe is enabled and low, and data is not enabled.
- R7: Words occupy consecutive slots, one per half cycle. The strobe is high for even words and low for odd words. `dq` carries the array word for the column in R5 and the row opened by the bank's most recent ACT.
- R8: The data enable drops in the slot right after the last word, and `dq` reads 0 whenever the data enable is low.
- R9: For two slots after the last word the strobe stays enabled and low, and then its enable drops.
- R10: A READ that arrives while any earlier burst is still pending, running or in its postamble is rejected as in R1. The one exception is a READ exactly N/2 device cycles after the previous accepted READ, where N is that read's burst length. Such a READ is accepted, and its words follow the previous burst with no gap, no preamble and no postamble between them.
- R11: During and right after reset, all outputs are low. The mode holds a 4-word burst, the maximum latency and sequential ordering, and all banks are closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the device rate, one slot per edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Command: 0 no-op, 1 activate, 2 read, 3 treated as no-op |
| bank | input | 2 | Bank select for activate and read |
| addr | input | 12 | Row for activate; low 8 bits are the start column for read |
| mode_we | input | 1 | Mode write strobe, sampled on device edges |
| mode_blc | input | 2 | Burst length code |
| mode_cl | input | 2 | Latency in device cycles |
| mode_bt | input | 1 | Ordering: 0 sequential, 1 interleaved |
| rd_en | output | 1 | Array read request for this slot |
| rd_bank | output | 2 | Array bank |
| rd_row | output | 12 | Array row |
| rd_col | output | 8 | Array column |
| rd_data | input | 16 | Array word, valid one slot after the request |
| dq | output | 16 | Data output, 0 when not enabled |
| dq_oe | output | 1 | Data output enable |
| dqs | output | 1 | Strobe output level |
| dqs_oe | output | 1 | Strobe output enable |
| cmd_err | output | 1 | One-slot pulse for a rejected READ |

## Verification
Two functions can land in the same cycle. The first is the last word of one burst together with the load of the next burst for a seamless continuation. The second is the postamble decision for the old burst. The bench provokes this by issuing a second READ exactly N/2 device cycles after the first, for 2-word and for 4-word bursts, including a chain of three. The expected slot trace must then show unbroken strobe toggling and no low strobe slot between the bursts. A READ issued one device cycle after an 8-word read makes the rejection path and the running burst share cycles. The trace must show the error pulse and an unchanged burst.

// File: rtl/ddrrd_pkg.sv
package ddrrd_pkg;

    localparam int unsigned BANK_W = 2;
    localparam int unsigned NBANK  = 1 << BANK_W;
    localparam int unsigned ROW_W  = 12;
    localparam int unsigned COL_W  = 8;
    localparam int unsigned KW     = 3;   // burst word index width (up to 8 words)

    typedef enum logic [1:0] {
        CMD_NOP  = 2'b00,
        CMD_ACT  = 2'b01,
        CMD_READ = 2'b10,
        CMD_RSVD = 2'b11
    } cmd_e;

    typedef enum logic {
        BT_SEQ   = 1'b0,
        BT_INTLV = 1'b1
    } bt_e;

    typedef struct packed {
        logic [1:0] blc;
        logic [1:0] cl;
        bt_e        bt;
    } mode_t;

    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [1:0]        blc;
        bt_e               bt;
    } rd_evt_t;

    // words in a burst for a burst-length code (1..3)
    function automatic logic [3:0] bl_words(input logic [1:0] blc);
        case (blc)
            2'd1:    return 4'd2;
            2'd2:    return 4'd4;
            2'd3:    return 4'd8;
            default: return 4'd4;
        endcase
    endfunction

    // column of word k, wrapping inside the burst-aligned block
    function automatic logic [COL_W-1:0] burst_col(input logic [COL_W-1:0] start,
                                                   input logic [1:0]       blc,
                                                   input bt_e              bt,
                                                   input logic [KW-1:0]    k);
        logic [KW-1:0] mask;
        logic [KW-1:0] low;
        logic [KW-1:0] off;
        mask = KW'(bl_words(blc) - 4'd1);
        low  = start[KW-1:0] & mask;
        off  = (bt == BT_INTLV) ? (low ^ k) : (low + k);
        off  = off & mask;
        return (start & ~COL_W'(mask)) | COL_W'(off);
    endfunction

endpackage

// File: rtl/ddrrd_bank_track.sv
module ddrrd_bank_track
    import ddrrd_pkg::*;
#(
    parameter int unsigned TRCD = 3
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              dev_edge,
    input  logic              act_vld,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [ROW_W-1:0]  act_row,
    input  logic [BANK_W-1:0] q_bank,
    output logic              q_open,
    output logic              q_ready,
    output logic [ROW_W-1:0]  q_row
);
    localparam int unsigned AGE_W = $clog2(TRCD + 1) + 1;
    localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(TRCD);

    logic [NBANK-1:0]  open_q;
    logic [NBANK-1:0]  ready_q;
    logic [ROW_W-1:0]  row_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [AGE_W-1:0] age;
        logic             hit;
        assign hit        = act_vld && (act_bank == BANK_W'(b));
        assign ready_q[b] = open_q[b] && (age >= AGE_SAT);

        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[b] <= 1'b0;
                age       <= '0;
                row_q[b]  <= '0;
            end else if (hit) begin
                // age counts device edges since the ACT, starting at 1
                open_q[b] <= 1'b1;
                age       <= AGE_W'(1);
                row_q[b]  <= act_row;
            end else if (dev_edge && open_q[b] && (age < AGE_SAT)) begin
                age <= age + AGE_W'(1);
            end
        end
    end

    assign q_open  = open_q[q_bank];
    assign q_ready = ready_q[q_bank];
    assign q_row   = row_q[q_bank];

endmodule

// File: rtl/ddrrd_lat_pipe.sv
module ddrrd_lat_pipe
    import ddrrd_pkg::*;
#(
    parameter int unsigned CL_MAX = 3
)(
    input  logic    clk,
    input  logic    rst,
    input  logic [1:0] cl,
    input  rd_evt_t in_evt,
    output logic    pre_vld,
    output rd_evt_t pop_evt,
    output logic    busy
);
    localparam int unsigned DEPTH = 2 * CL_MAX - 1;

    rd_evt_t           stg [DEPTH];
    logic [DEPTH-1:0]  vld_vec;
    int unsigned       tap;

    // pop one slot before the first word, preamble one slot earlier
    assign tap     = 2 * int'(cl) - 2;
    assign pop_evt = stg[tap];
    assign pre_vld = stg[tap - 1].vld;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        assign vld_vec[i] = stg[i].vld;
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= in_evt;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)                      stg[i] <= '0;
                else if (i <= int'(tap))      stg[i] <= stg[i-1];
                else                          stg[i] <= '0;
            end
        end
    end

    assign busy = |vld_vec;

endmodule

// File: rtl/ddrrd_burst_eng.sv
module ddrrd_burst_eng
    import ddrrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rd_evt_t           pop_evt,
    output logic              eng_act,
    output logic [KW-1:0]     eng_k,
    output logic [BANK_W-1:0] rd_bank,
    output logic [ROW_W-1:0]  rd_row,
    output logic [COL_W-1:0]  rd_col
);
    rd_evt_t       cur;
    logic          last;
    logic [KW-1:0] k_end;

    assign k_end = KW'(bl_words(cur.blc) - 4'd1);
    assign last  = eng_act && (eng_k == k_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            eng_act <= 1'b0;
            eng_k   <= '0;
            cur     <= '0;
        end else if (pop_evt.vld && (!eng_act || last)) begin
            eng_act <= 1'b1;
            eng_k   <= '0;
            cur     <= pop_evt;
        end else if (eng_act) begin
            if (last) eng_act <= 1'b0;
            else      eng_k   <= eng_k + KW'(1);
        end
    end

    assign rd_bank = cur.bank;
    assign rd_row  = cur.row;
    assign rd_col  = burst_col(cur.col, cur.blc, cur.bt, eng_k);

endmodule

// File: rtl/ddrrd_strobe_ctl.sv
module ddrrd_strobe_ctl
    import ddrrd_pkg::*;
#(
    parameter int unsigned DQ_W = 16
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            eng_act,
    input  logic            eng_k0,
    input  logic            pre_vld,
    input  logic [DQ_W-1:0] rd_data,
    output logic [DQ_W-1:0] dq,
    output logic            dq_oe,
    output logic            dqs,
    output logic            dqs_oe,
    output logic            busy
);
    logic d_act;
    logic d_k0;
    logic pre_a;
    logic post1;
    logic post2;

    always_ff @(posedge clk) begin
        if (rst) begin
            d_act <= 1'b0;
            d_k0  <= 1'b0;
            pre_a <= 1'b0;
            post1 <= 1'b0;
            post2 <= 1'b0;
        end else begin
            d_act <= eng_act;
            d_k0  <= eng_k0;
            pre_a <= pre_vld;
            post1 <= d_act && !eng_act;
            post2 <= post1;
        end
    end

    assign dq_oe  = d_act;
    assign dq     = d_act ? rd_data : '0;
    assign dqs    = d_act && !d_k0;
    assign dqs_oe = d_act || eng_act || pre_a || post1 || post2;
    assign busy   = d_act || pre_a || post1 || post2;

endmodule

// File: rtl/ddrrd_read_seq.sv
module ddrrd_read_seq
    import ddrrd_pkg::*;
#(
    parameter int unsigned DQ_W   = 16,
    parameter int unsigned TRCD   = 3,
    parameter int unsigned CL_MAX = 3
)(
    input  logic              clk2x,
    input  logic              rst,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  addr,
    input  logic              mode_we,
    input  logic [1:0]        mode_blc,
    input  logic [1:0]        mode_cl,
    input  logic              mode_bt,
    output logic              rd_en,
    output logic [BANK_W-1:0] rd_bank,
    output logic [ROW_W-1:0]  rd_row,
    output logic [COL_W-1:0]  rd_col,
    input  logic [DQ_W-1:0]   rd_data,
    output logic [DQ_W-1:0]   dq,
    output logic              dq_oe,
    output logic              dqs,
    output logic              dqs_oe,
    output logic              cmd_err
);
    localparam int unsigned SA_W = 3;
    localparam logic [SA_W-1:0] SA_MAX = '1;

    logic       ph;
    logic       dev_edge;
    mode_t      mode_q;
    cmd_e       cmd_d;
    logic       is_act;
    logic       is_read;
    logic       bk_open;
    logic       bk_ready;
    logic [ROW_W-1:0] bk_row;
    logic       pipe_busy;
    logic       strb_busy;
    logic       eng_act;
    logic [KW-1:0] eng_k;
    logic       pre_vld;
    rd_evt_t    pop_evt;
    rd_evt_t    new_evt;
    logic       busy;
    logic       seam_ok;
    logic       accept;
    logic [SA_W-1:0] since_acc;
    logic [1:0] last_blc;

    // ph low in the slot before a device rising edge
    always_ff @(posedge clk2x) begin
        if (rst) ph <= 1'b0;
        else     ph <= ~ph;
    end
    assign dev_edge = ~ph;

    assign cmd_d   = cmd_e'(cmd);
    assign is_act  = dev_edge && (cmd_d == CMD_ACT);
    assign is_read = dev_edge && (cmd_d == CMD_READ);

    // mode store: illegal codes keep the previous field
    always_ff @(posedge clk2x) begin
        if (rst) begin
            mode_q.blc <= 2'd2;
            mode_q.cl  <= 2'(CL_MAX);
            mode_q.bt  <= BT_SEQ;
        end else if (dev_edge && mode_we) begin
            if (mode_blc != 2'd0) mode_q.blc <= mode_blc;
            if ((int'(mode_cl) >= 2) && (int'(mode_cl) <= int'(CL_MAX)))
                mode_q.cl <= mode_cl;
            mode_q.bt <= bt_e'(mode_bt);
        end
    end

    ddrrd_bank_track #(.TRCD(TRCD)) u_bank (
        .clk      (clk2x),
        .rst      (rst),
        .dev_edge (dev_edge),
        .act_vld  (is_act),
        .act_bank (bank),
        .act_row  (addr),
        .q_bank   (bank),
        .q_open   (bk_open),
        .q_ready  (bk_ready),
        .q_row    (bk_row)
    );

    assign busy    = pipe_busy || eng_act || strb_busy;
    assign seam_ok = (since_acc == SA_W'(bl_words(last_blc) >> 1));
    assign accept  = is_read && bk_open && bk_ready && (!busy || seam_ok);

    always_comb begin
        new_evt      = '0;
        new_evt.vld  = accept;
        new_evt.bank = bank;
        new_evt.row  = bk_row;
        new_evt.col  = addr[COL_W-1:0];
        new_evt.blc  = mode_q.blc;
        new_evt.bt   = mode_q.bt;
    end

    // device cycles since the last accepted read, for seamless timing
    always_ff @(posedge clk2x) begin
        if (rst) begin
            since_acc <= SA_MAX;
            last_blc  <= 2'd1;
            cmd_err   <= 1'b0;
        end else begin
            cmd_err <= is_read && !accept;
            if (accept) begin
                since_acc <= SA_W'(1);
                last_blc  <= mode_q.blc;
            end else if (dev_edge && (since_acc != SA_MAX)) begin
                since_acc <= since_acc + SA_W'(1);
            end
        end
    end

    ddrrd_lat_pipe #(.CL_MAX(CL_MAX)) u_pipe (
        .clk     (clk2x),
        .rst     (rst),
        .cl      (mode_q.cl),
        .in_evt  (new_evt),
        .pre_vld (pre_vld),
        .pop_evt (pop_evt),
        .busy    (pipe_busy)
    );

    ddrrd_burst_eng u_eng (
        .clk     (clk2x),
        .rst     (rst),
        .pop_evt (pop_evt),
        .eng_act (eng_act),
        .eng_k   (eng_k),
        .rd_bank (rd_bank),
        .rd_row  (rd_row),
        .rd_col  (rd_col)
    );
    assign rd_en = eng_act;

    ddrrd_strobe_ctl #(.DQ_W(DQ_W)) u_strb (
        .clk     (clk2x),
        .rst     (rst),
        .eng_act (eng_act),
        .eng_k0  (eng_k[0]),
        .pre_vld (pre_vld),
        .rd_data (rd_data),
        .dq      (dq),
        .dq_oe   (dq_oe),
        .dqs     (dqs),
        .dqs_oe  (dqs_oe),
        .busy    (strb_busy)
    );

endmodule

// File: rtl/ddrrd_read_seq_chk.sv
module ddrrd_read_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cmd,
    input logic       dq_oe,
    input logic       dqs,
    input logic       dqs_oe,
    input logic       cmd_err
);
    AST_ERR_FROM_READ: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> ($past(cmd) == 2'b10)); // R1

    AST_DATA_UNDER_STROBE: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> dqs_oe); // R7

    AST_STROBE_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && $past(dq_oe)) |-> (dqs != $past(dqs))); // R7

    AST_PREAMBLE_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(dqs_oe) |-> (!dqs && !dq_oe)); // R6

    AST_DATA_RELEASE_POST: assert property (@(posedge clk) disable iff (rst)
        $fell(dq_oe) |-> (dqs_oe && !dqs)); // R8

    AST_STROBE_RELEASE_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(dqs_oe) |-> $past(!dqs && !dq_oe)); // R9

endmodule

bind ddrrd_read_seq ddrrd_read_seq_chk u_chk (
    .clk     (clk2x),
    .rst     (rst),
    .cmd     (cmd),
    .dq_oe   (dq_oe),
    .dqs     (dqs),
    .dqs_oe  (dqs_oe),
    .cmd_err (cmd_err)
);

// File: tb/sim_ddrrd_read_seq.sv
module sim_ddrrd_read_seq;
    localparam int SLOTS = 8192;
    localparam int TRCD  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cmd = 2'b00;
    logic [1:0]  bank = 2'b00;
    logic [11:0] addr = '0;
    logic        mode_we = 1'b0;
    logic [1:0]  mode_blc = 2'd0;
    logic [1:0]  mode_cl = 2'd0;
    logic        mode_bt = 1'b0;
    logic        rd_en;
    logic [1:0]  rd_bank;
    logic [11:0] rd_row;
    logic [7:0]  rd_col;
    logic [15:0] rd_data = '0;
    logic [15:0] dq;
    logic        dq_oe, dqs, dqs_oe, cmd_err;

    int checks = 0;
    int errors = 0;
    int slot   = 0;
    bit chk_on = 1'b0;
    bit done   = 1'b0;

    bit          e_dqoe [SLOTS];
    bit          e_dqsoe[SLOTS];
    bit          e_dqs  [SLOTS];
    logic [15:0] e_dq   [SLOTS];
    bit          e_err  [SLOTS];
    string       e_tag  [SLOTS];
    string       e_etag [SLOTS];

    int m_blc = 2;
    int m_cl  = 3;
    int m_bt  = 0;
    int rows[4] = '{12'h0C5, 12'h11A, 12'h27F, 12'h330};

    always #5 clk = ~clk;

    ddrrd_read_seq u0 (
        .clk2x(clk), .rst(rst), .cmd(cmd), .bank(bank), .addr(addr),
        .mode_we(mode_we), .mode_blc(mode_blc), .mode_cl(mode_cl), .mode_bt(mode_bt),
        .rd_en(rd_en), .rd_bank(rd_bank), .rd_row(rd_row), .rd_col(rd_col),
        .rd_data(rd_data), .dq(dq), .dq_oe(dq_oe), .dqs(dqs), .dqs_oe(dqs_oe),
        .cmd_err(cmd_err)
    );

    // synchronous array model: word encodes bank, low row bits and column
    always @(posedge clk) begin
        if (rd_en) rd_data <= {rd_bank, rd_row[5:0], rd_col};
    end

    always @(posedge clk) begin
        if (!rst) slot <= slot + 1;
    end

    initial begin
        for (int i = 0; i < SLOTS; i++) begin
            e_dq[i] = '0; e_tag[i] = "R10"; e_etag[i] = "R10";
        end
    end

    // slot-by-slot comparison against the expected trace
    always @(negedge clk) begin
        if (!rst && chk_on && slot < SLOTS) begin
            checks++;
            if (dq_oe !== e_dqoe[slot] || dqs_oe !== e_dqsoe[slot] ||
                dqs !== e_dqs[slot] || dq !== e_dq[slot]) begin
                errors++;
                $display("FAIL %s slot %0d oe/soe/s/dq act %b%b%b %h exp %b%b%b %h",
                         e_tag[slot], slot, dq_oe, dqs_oe, dqs, dq,
                         e_dqoe[slot], e_dqsoe[slot], e_dqs[slot], e_dq[slot]);
            end
            checks++;
            if (cmd_err !== e_err[slot]) begin
                errors++;
                $display("FAIL %s slot %0d cmd_err act %b exp %b",
                         e_etag[slot], slot, cmd_err, e_err[slot]);
            end
        end
    end

    function automatic int exp_col(int c, int n, int bt, int k);
        int mask, low, off;
        mask = n - 1;
        low  = c & mask;
        off  = bt ? (low ^ k) : ((low + k) & mask);
        return (c & ~mask & 255) | off;
    endfunction

    task automatic sched(int t, int b, int c, bit seam);
        int n, s0;
        n  = 1 << m_blc;
        s0 = t + 2 * m_cl;
        if (!seam) begin
            for (int p = 0; p < 2; p++) begin   // R6 preamble
                e_dqsoe[s0-2+p] = 1; e_dqs[s0-2+p] = 0; e_dqoe[s0-2+p] = 0;
                e_tag[s0-2+p] = "R6";
            end
        end
        for (int k = 0; k < n; k++) begin       // R4 first word, R5/R7 words
            e_dqoe[s0+k] = 1; e_dqsoe[s0+k] = 1; e_dqs[s0+k] = (k % 2 == 0);
            e_dq[s0+k] = {2'(b), 6'(rows[b]), 8'(exp_col(c, n, m_bt, k))};
            e_tag[s0+k] = (k == 0) ? "R4" : ((m_bt != 0) ? "R5" : "R7");
        end
        for (int p = 0; p < 2; p++) begin       // R8 data release, R9 postamble
            e_dqoe[s0+n+p] = 0; e_dqsoe[s0+n+p] = 1; e_dqs[s0+n+p] = 0;
            e_dq[s0+n+p] = '0;
            e_tag[s0+n+p] = (p == 0) ? "R8" : "R9";
        end
    endtask

    task automatic dev(input logic [1:0] c, input int b, input int a);
        cmd = c; bank = 2'(b); addr = 12'(a);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        cmd = 2'b00; mode_we = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) dev(2'b00, 0, 0);
    endtask

    task automatic setmode(int blc, int cl, int bt);
        mode_we = 1'b1; mode_blc = 2'(blc); mode_cl = 2'(cl); mode_bt = bt[0];
        if (blc != 0) m_blc = blc;          // R3 code rules
        if (cl >= 2 && cl <= 3) m_cl = cl;
        m_bt = bt;
        dev(2'b00, 0, 0);
    endtask

    task automatic do_read(int b, int c, bit seam, bit bad, string etag);
        int t;
        t = slot + 1;
        if (bad) begin
            e_err[t] = 1; e_etag[t] = etag;
        end else begin
            sched(t, b, c, seam);
        end
        dev(2'b10, b, c);
    endtask

    task automatic drain();
        idle(m_cl + (1 << m_blc) / 2 + 2);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        checks++;
        if (dq_oe !== 0 || dqs_oe !== 0 || dqs !== 0 || rd_en !== 0 || cmd_err !== 0 || dq !== 0) begin
            errors++;
            $display("FAIL R11 reset outputs act %b%b%b%b%b %h exp 00000 0000",
                     dq_oe, dqs_oe, dqs, rd_en, cmd_err, dq);
        end
        rst = 1'b0;
        chk_on = 1'b1;

        // R1: read to a closed bank
        do_read(0, 8'h10, 0, 1, "R1");
        idle(2);

        // R2: too early by one device cycle, then exactly on time (default mode R11)
        dev(2'b01, 0, rows[0]);
        idle(1);
        do_read(0, 8'h21, 0, 1, "R2");
        do_read(0, 8'h22, 0, 0, "");
        drain();

        for (int b = 1; b < 4; b++) dev(2'b01, b, rows[b]);
        idle(TRCD);

        // R4 R5 R7 sweep over length, latency, ordering and start column
        for (int bl = 1; bl <= 3; bl++) begin
            for (int cl = 2; cl <= 3; cl++) begin
                for (int bt = 0; bt < 2; bt++) begin
                    for (int c = 0; c < 8; c++) begin
                        int col;
                        col = (c * 33 + 16 * bt) & 255;
                        setmode(bl, cl, bt);
                        do_read(c % 4, col, 0, 0, "");
                        drain();
                    end
                end
            end
        end

        // R3: illegal codes are ignored
        setmode(2, 3, 0);
        setmode(0, 1, 1);
        do_read(1, 8'h4D, 0, 0, "");
        drain();

        // R10: busy rejection during an 8-word read
        setmode(3, 3, 0);
        do_read(2, 8'h63, 0, 0, "");
        do_read(3, 8'h70, 0, 1, "R10");
        drain();

        // R10: seamless continuation, 2-word bursts
        setmode(1, 3, 0);
        do_read(0, 8'h81, 0, 0, "");
        do_read(1, 8'h92, 1, 0, "");
        drain();

        // R10: chain of three seamless 4-word bursts, interleaved
        setmode(2, 2, 1);
        do_read(2, 8'hA5, 0, 0, "");
        idle(1);
        do_read(3, 8'hB6, 1, 0, "");
        idle(1);
        do_read(0, 8'hC7, 1, 0, "");
        drain();

        // R7: a new ACT replaces the row seen in the data
        dev(2'b01, 2, 12'h14B);
        rows[2] = 12'h14B;
        idle(TRCD);
        do_read(2, 8'h33, 0, 0, "");
        drain();
        idle(2);

        chk_on = 1'b0;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog act running exp finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule